// File: doc/BRIEF.md
# Multi-Source Reset Domain Controller

This block merges every hardware reset source of a device into three separate reset outputs: one for the general core logic, one for the serial-link physical layer, and one for the sticky configuration bits. The sources are two active-low pins, a cold reset and a warm reset. There are also four single-cycle event strobes from a serial-link endpoint: hot reset, loopback, disable link and link down. Each source clears its own set of domains. Each domain output is pulled low at once, with no clock needed, and goes high again only after a short synchronizer on that domain's own clock.

The block also latches the device straps when a reset ends. A full strap register takes all strap bits when the pin resets end. A partial strap register takes the low bits whenever the core domain leaves reset, and that includes resets started by a link event. A link event holds its core reset request for a programmable minimum number of core clock cycles before release can begin. A link event has any effect only while the device runs as an endpoint with its serial link enabled.

There is no data path, so every pin is a plain level or strobe. No handshake or back-pressure applies.

Top module: `rstdom_ctrl`

## Requirements
- R1: While `cold_rst_n` is low, `core_rst_n`, `phy_rst_n` and `stky_rst_n` are all low, and they go low without waiting for a clock edge.
- R2: Each reset output goes high on the second rising edge of its domain clock after the last source covering that domain has cleared (SYNC_STAGES = 2).
- R3: While `warm_rst_n` is low, `core_rst_n` and `phy_rst_n` are low and `stky_rst_n` keeps its value; only `cold_rst_n` ever drives `stky_rst_n` low.
- R4: A qualified strobe on `ev_hot`, `ev_loop` or `ev_dis` pulls only `core_rst_n` low; `phy_rst_n` and `stky_rst_n` stay high.
- R5: A qualified strobe on `ev_down` pulls `core_rst_n` and `phy_rst_n` low and leaves `stky_rst_n` high.
- R6: An event strobe is qualified only when `ep_mode` and `link_en` are both 1 at the rising `clk_core` edge that samples it. An unqualified strobe, or any strobe seen while a pin reset is low, changes no output.
- R7: A qualified strobe sampled at edge e keeps that event's reset request active through edge e+STRETCH, so `core_rst_n` is high again after edge e+STRETCH+2. A new strobe of the same event during that window restarts the count.
- R8: When sources overlap, a domain stays in reset until every source covering it has cleared, and release then follows R2 from the latest of them. A pin reset also cancels any event window in progress.
- R9: `strap_full` takes all STRAP_W bits of `strap_in` at the `clk_core` edge two edges after the later of the two pins has gone high. It holds that value at every other time.
- R10: `strap_part` takes `strap_in[PART_W-1:0]` at the `clk_core` edge where `core_rst_n` goes high, whatever source ended. A link-event reset leaves `strap_full` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core domain clock; also samples the strobes and the straps |
| clk_phy | input | 1 | Physical-layer domain clock |
| clk_stky | input | 1 | Sticky-bit domain clock |
| cold_rst_n | input | 1 | Cold reset pin, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset pin, active low, asynchronous |
| ep_mode | input | 1 | 1 when the device runs as a link endpoint |
| link_en | input | 1 | 1 when the serial-link interface is enabled |
| ev_hot | input | 1 | Hot-reset strobe, synchronous to clk_core |
| ev_loop | input | 1 | Loopback-entry strobe, synchronous to clk_core |
| ev_dis | input | 1 | Disable-link strobe, synchronous to clk_core |
| ev_down | input | 1 | Link-down strobe, synchronous to clk_core |
| strap_in | input | STRAP_W | Strap pin levels |
| core_rst_n | output | 1 | Core domain reset, active low |
| phy_rst_n | output | 1 | Physical-layer domain reset, active low |
| stky_rst_n | output | 1 | Sticky-bit domain reset, active low |
| strap_full | output | STRAP_W | All straps, taken when the pin resets end |
| strap_part | output | PART_W | Low straps, taken at every core release |

## Verification
The assertions assume that the event strobes and `ep_mode`/`link_en` change only away from the `clk_core` rising edge. They also assume that a pin reset never rises or falls near a rising clock edge, so each release takes a predictable number of edges. The sticky and strap properties further assume that `strap_in` stays steady for at least two core cycles after any reset clears. The stimulus changes every input just after a falling edge and holds each pin reset for several cycles. It feeds a single 125 MHz clock to all three domains, so cross-domain timing never shifts a release.

// File: rtl/rstdom_pkg.sv
package rstdom_pkg;
  // Event slot indices; the order fixes which slot reaches the physical layer.
  localparam int EV_HOT  = 0;
  localparam int EV_LOOP = 1;
  localparam int EV_DIS  = 2;
  localparam int EV_DOWN = 3;
  localparam int EV_NUM  = 4;

  // Per-event flag: does this event also clear the physical layer?
  localparam logic [EV_NUM-1:0] EV_PHY_MASK = 4'b1000;

  typedef struct packed {
    logic core;
    logic phy;
    logic stky;
  } dom_req_t;
endpackage

// File: rtl/rstdom_sync.sv
module rstdom_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic req,
  output logic rst_n,
  output logic rel_edge
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or posedge req) begin
    if (req) ff <= '0;
    else     ff <= {ff[STAGES-2:0], 1'b1};
  end

  assign rst_n    = ff[STAGES-1];
  // High during the cycle just before the final stage turns to 1.
  assign rel_edge = ff[STAGES-2] & ~ff[STAGES-1];
endmodule

// File: rtl/rstdom_stretch.sv
module rstdom_stretch #(
  parameter int STRETCH = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic fire,
  output logic active
);
  localparam int CNT_W = (STRETCH > 1) ? $clog2(STRETCH) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (fire) begin
      active <= 1'b1;
      cnt    <= CNT_W'(STRETCH - 1);
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rstdom_strap.sv
module rstdom_strap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Deliberately not reset: the content must survive the reset it follows.
  always_ff @(posedge clk) begin
    if (cap) q <= d;
  end
endmodule

// File: rtl/rstdom_ctrl.sv
module rstdom_ctrl
  import rstdom_pkg::*;
#(
  parameter int STRAP_W     = 8,
  parameter int PART_W      = 3,
  parameter int STRETCH     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_core,
  input  logic               clk_phy,
  input  logic               clk_stky,
  input  logic               cold_rst_n,
  input  logic               warm_rst_n,
  input  logic               ep_mode,
  input  logic               link_en,
  input  logic               ev_hot,
  input  logic               ev_loop,
  input  logic               ev_dis,
  input  logic               ev_down,
  input  logic [STRAP_W-1:0] strap_in,
  output logic               core_rst_n,
  output logic               phy_rst_n,
  output logic               stky_rst_n,
  output logic [STRAP_W-1:0] strap_full,
  output logic [PART_W-1:0]  strap_part
);
  logic              pin_req;
  logic              ev_qual;
  logic [EV_NUM-1:0] ev_vec;
  logic [EV_NUM-1:0] ev_act;
  logic [EV_NUM-1:0] ev_phy_hit;
  dom_req_t          dreq;
  logic              pin_rst_n;
  logic              pin_rel;
  logic              core_rel;
  logic              phy_rel;
  logic              stky_rel;

  assign pin_req = ~cold_rst_n | ~warm_rst_n;
  assign ev_qual = ep_mode & link_en;

  always_comb begin
    ev_vec          = '0;
    ev_vec[EV_HOT]  = ev_hot;
    ev_vec[EV_LOOP] = ev_loop;
    ev_vec[EV_DIS]  = ev_dis;
    ev_vec[EV_DOWN] = ev_down;
  end

  for (genvar g = 0; g < EV_NUM; g++) begin : g_evt
    rstdom_stretch #(.STRETCH(STRETCH)) i_stretch (
      .clk    (clk_core),
      .clr    (pin_req),
      .fire   (ev_vec[g] & ev_qual),
      .active (ev_act[g])
    );
    assign ev_phy_hit[g] = ev_act[g] & EV_PHY_MASK[g];
  end

  assign dreq.core = pin_req | (|ev_act);
  assign dreq.phy  = pin_req | (|ev_phy_hit);
  assign dreq.stky = ~cold_rst_n;

  rstdom_sync #(.STAGES(SYNC_STAGES)) i_sync_core (
    .clk (clk_core), .req (dreq.core), .rst_n (core_rst_n), .rel_edge (core_rel)
  );
  rstdom_sync #(.STAGES(SYNC_STAGES)) i_sync_phy (
    .clk (clk_phy), .req (dreq.phy), .rst_n (phy_rst_n), .rel_edge (phy_rel)
  );
  rstdom_sync #(.STAGES(SYNC_STAGES)) i_sync_stky (
    .clk (clk_stky), .req (dreq.stky), .rst_n (stky_rst_n), .rel_edge (stky_rel)
  );
  // Pin-only tracker on the core clock: times the full strap capture.
  rstdom_sync #(.STAGES(SYNC_STAGES)) i_sync_pin (
    .clk (clk_core), .req (pin_req), .rst_n (pin_rst_n), .rel_edge (pin_rel)
  );

  rstdom_strap #(.W(STRAP_W)) i_strap_full (
    .clk (clk_core), .cap (pin_rel), .d (strap_in), .q (strap_full)
  );
  rstdom_strap #(.W(PART_W)) i_strap_part (
    .clk (clk_core), .cap (core_rel), .d (strap_in[PART_W-1:0]), .q (strap_part)
  );

  logic unused_ok;
  assign unused_ok = &{1'b0, pin_rst_n, phy_rel, stky_rel};
endmodule

// File: rtl/rstdom_ctrl_chk.sv
module rstdom_ctrl_chk #(
  parameter int STRAP_W = 8,
  parameter int PART_W  = 3
) (
  input logic               clk_core,
  input logic               clk_stky,
  input logic               cold_rst_n,
  input logic               warm_rst_n,
  input logic               ep_mode,
  input logic               link_en,
  input logic               core_rst_n,
  input logic               phy_rst_n,
  input logic               stky_rst_n,
  input logic [STRAP_W-1:0] strap_full,
  input logic [PART_W-1:0]  strap_part
);
  // R1: cold reset holds every domain
  always @(posedge clk_core) begin
    if (!cold_rst_n) begin
      a_r1_cold_all: assert (!core_rst_n && !phy_rst_n && !stky_rst_n)
        else $error("R1 cold reset left a domain running");
    end
  end

  a_r3_warm_core_phy: assert property (@(posedge clk_core) disable iff (!cold_rst_n)
    !warm_rst_n |-> (!core_rst_n && !phy_rst_n))
    else $error("R3 warm reset did not hold core and phy");

  a_r3_sticky_kept: assert property (@(posedge clk_stky) disable iff (!cold_rst_n)
    stky_rst_n |=> stky_rst_n)
    else $error("R3 sticky domain reset without cold reset");

  a_r6_unqualified_ignored: assert property (@(posedge clk_core)
    disable iff (!cold_rst_n || !warm_rst_n)
    (core_rst_n && !(ep_mode && link_en)) |=> core_rst_n)
    else $error("R6 unqualified event reset the core");

  a_r10_straps_hold: assert property (@(posedge clk_core) disable iff (!cold_rst_n)
    (core_rst_n && $past(core_rst_n)) |-> ($stable(strap_full) && $stable(strap_part)))
    else $error("R10 straps moved outside a release");
endmodule

bind rstdom_ctrl rstdom_ctrl_chk #(.STRAP_W(STRAP_W), .PART_W(PART_W)) i_chk (
  .clk_core   (clk_core),
  .clk_stky   (clk_stky),
  .cold_rst_n (cold_rst_n),
  .warm_rst_n (warm_rst_n),
  .ep_mode    (ep_mode),
  .link_en    (link_en),
  .core_rst_n (core_rst_n),
  .phy_rst_n  (phy_rst_n),
  .stky_rst_n (stky_rst_n),
  .strap_full (strap_full),
  .strap_part (strap_part)
);

// File: tb/test_rstdom_ctrl.sv
module test_rstdom_ctrl;
  localparam int SW = 8;
  localparam int PW = 3;
  localparam int ST = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          cold_rst_n, warm_rst_n, ep_mode, link_en;
  logic          ev_hot, ev_loop, ev_dis, ev_down;
  logic [SW-1:0] strap_in;
  logic          core_rst_n, phy_rst_n, stky_rst_n;
  logic [SW-1:0] strap_full;
  logic [PW-1:0] strap_part;

  rstdom_ctrl #(.STRAP_W(SW), .PART_W(PW), .STRETCH(ST), .SYNC_STAGES(2)) i_rstdom_ctrl (
    .clk_core (clk), .clk_phy (clk), .clk_stky (clk),
    .cold_rst_n, .warm_rst_n, .ep_mode, .link_en,
    .ev_hot, .ev_loop, .ev_dis, .ev_down, .strap_in,
    .core_rst_n, .phy_rst_n, .stky_rst_n, .strap_full, .strap_part
  );

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";
  bit    done   = 1'b0;

  // Reference model state
  int            rem [4] = '{0, 0, 0, 0};
  int            ok_core = 0, ok_phy = 0, ok_stky = 0, ok_pin = 0;
  logic [SW-1:0] m_full = '0;
  logic [PW-1:0] m_part = '0;
  bit            have_full = 1'b0, have_part = 1'b0;

  function automatic bit any_act();
    return (rem[0] > 0) || (rem[1] > 0) || (rem[2] > 0) || (rem[3] > 0);
  endfunction

  always @(posedge clk) begin
    bit pin, creq, preq, sreq;
    bit evs [4];
    pin  = !cold_rst_n || !warm_rst_n;
    creq = pin || any_act();
    preq = pin || (rem[3] > 0);
    sreq = !cold_rst_n;
    if (creq) ok_core = 0;
    else begin
      if (ok_core == 1) begin m_part = strap_in[PW-1:0]; have_part = 1'b1; end
      if (ok_core < 2) ok_core++;
    end
    if (pin) ok_pin = 0;
    else begin
      if (ok_pin == 1) begin m_full = strap_in; have_full = 1'b1; end
      if (ok_pin < 2) ok_pin++;
    end
    if (preq) ok_phy = 0; else if (ok_phy < 2) ok_phy++;
    if (sreq) ok_stky = 0; else if (ok_stky < 2) ok_stky++;
    evs = '{ev_hot, ev_loop, ev_dis, ev_down};
    for (int i = 0; i < 4; i++) begin
      if (pin) rem[i] = 0;
      else if (evs[i] && ep_mode && link_en) rem[i] = ST;
      else if (rem[i] > 0) rem[i]--;
    end
  end

  task automatic chk(string what, logic [SW-1:0] act, logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit pin_now;
    #3;
    if (!done) begin
      pin_now = !cold_rst_n || !warm_rst_n;
      chk("core_rst_n", SW'(core_rst_n), SW'(!(pin_now || any_act()) && ok_core >= 2));
      chk("phy_rst_n",  SW'(phy_rst_n),  SW'(!(pin_now || rem[3] > 0) && ok_phy >= 2));
      chk("stky_rst_n", SW'(stky_rst_n), SW'(cold_rst_n && ok_stky >= 2));
      if (have_full) chk("strap_full", strap_full, m_full);
      if (have_part) chk("strap_part", SW'(strap_part), SW'(m_part));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse(int which);
    case (which)
      0: ev_hot  = 1'b1;
      1: ev_loop = 1'b1;
      2: ev_dis  = 1'b1;
      default: ev_down = 1'b1;
    endcase
    step(1);
    {ev_hot, ev_loop, ev_dis, ev_down} = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    cold_rst_n = 1'b0; warm_rst_n = 1'b1; ep_mode = 1'b0; link_en = 1'b0;
    {ev_hot, ev_loop, ev_dis, ev_down} = '0;
    strap_in = 8'hA5;
    tag = "R1"; step(5);
    tag = "R2,R9"; cold_rst_n = 1'b1; step(4);
    strap_in = 8'h3C; step(3);                 // R9 held after capture
    tag = "R6"; link_en = 1'b1; pulse(0); step(4);
    ep_mode = 1'b1; link_en = 1'b0; pulse(3); step(4);
    link_en = 1'b1;
    tag = "R4,R10"; strap_in = 8'h5B; pulse(0); step(22);
    strap_in = 8'h66; pulse(1); step(22);
    strap_in = 8'h71; pulse(2); step(22);
    tag = "R5"; strap_in = 8'h0E; pulse(3); step(22);
    tag = "R7"; pulse(0); step(8); pulse(0); step(24);
    tag = "R3"; warm_rst_n = 1'b0; step(4);
    tag = "R6"; pulse(0); step(2);
    tag = "R9"; strap_in = 8'hC3; warm_rst_n = 1'b1; step(6);
    tag = "R8"; pulse(3); step(4); warm_rst_n = 1'b0; step(3); warm_rst_n = 1'b1; step(8);
    pulse(0); step(5); pulse(3); step(26);
    pulse(0); step(3); pulse(1); step(24);
    tag = "R1"; pulse(0); step(3); cold_rst_n = 1'b0; step(3);
    tag = "R2,R9"; strap_in = 8'h99; cold_rst_n = 1'b1; step(8);
    finish_run();
  end
endmodule